// File: doc/BRIEF.md
# Multiplexed Address/Data Write Master

This block drives single write transactions onto a 64-bit bus whose data lines also carry the address. A request from the internal side supplies an address, an access-size code, the write data and a count of internal wait states. The block then opens a bus frame. The first cycle is the header: it places the size code in the top three data bits and the address in the low 26 bits. The cycles that follow are data cycles, in which the write data sits on the same lines.

Between the header and the final data cycle, the block inserts the programmed number of internal wait cycles. After those have passed, the final data cycle repeats for as long as the external ready input (active low) stays deasserted. When ready is seen, the data cycle completes. A one-cycle done pulse tells the requester that it may issue the next write.

Top module: `mpx_wr_master`

## Requirements
- R1: While reset is active, and in every idle cycle after it, the outputs cs_n_o, bs_n_o, frame_n_o and we_n_o are 1, bus_d_o is 0, req_ready_o is 1 and done_o is 0.
- R2: In the header cycle, bus_d_o[63:61] equals the requested size code (000 byte, 001 two bytes, 010 four bytes, 011 eight bytes, 1xx burst), passed through unchanged. bus_d_o[25:0] equals the address and bus_d_o[60:26] is zero.
- R3: bs_n_o is 0 in the header cycle only, which is the first cycle after the request is accepted.
- R4: frame_n_o is 0 from the header cycle through the last data cycle inclusive.
- R5: cs_n_o and we_n_o are 0 for the whole transaction and return to 1 in the cycle after the data cycle completes.
- R6: A wait count N > 0 places exactly N internal wait cycles between the header and the final data cycle. The write data is on bus_d_o during those wait cycles.
- R7: rdy_n_i is ignored during internal wait cycles: holding it at 1 there adds no cycle.
- R8: In the final data cycle, each cycle in which rdy_n_i is 1 extends the transaction by one data cycle.
- R9: done_o is 1 for exactly one cycle: the final data cycle in which rdy_n_i is 0.
- R10: req_ready_o is 0 from the header cycle to completion, and req_valid_i has no effect during that time.
- R11: With a wait count of 0, the data cycle directly follows the header cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request |
| req_ready_o | output | 1 | Idle, request accepted this cycle if valid |
| req_addr_i | input | 26 | Write address |
| req_size_i | input | 3 | Access-size code |
| req_data_i | input | 64 | Write data |
| req_wait_i | input | 4 | Internal wait count |
| done_o | output | 1 | Data cycle completes this cycle |
| rdy_n_i | input | 1 | External ready, active low |
| bus_d_o | output | 64 | Multiplexed header/data lines |
| cs_n_o | output | 1 | Chip select, active low |
| bs_n_o | output | 1 | Bus start, active low |
| frame_n_o | output | 1 | Frame, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
Writes run with zero, one and several internal waits, each with and without external waits. This separates the header-to-data timing from the length of the data phase. Holding ready deasserted during internal waits shows whether ready is wrongly sampled early. Size codes from byte through burst, together with all-ones addresses, show whether the header fields leak into the zero gap. Requests held asserted during a busy transaction show whether a request is wrongly accepted mid-frame.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_IWAIT = 2'd2,
    ST_DATA  = 2'd3
  } mpx_st_e;
endpackage

// File: rtl/mpx_hdr_fmt.sv
module mpx_hdr_fmt #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 26,
  parameter int SIZE_W = 3
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] hdr_o
);
  localparam int GAP_W = DATA_W - SIZE_W - ADDR_W;

  always_comb begin
    hdr_o = {size_i, {GAP_W{1'b0}}, addr_i};
  end
endmodule

// File: rtl/mpx_wait_ctr.sv
module mpx_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              zero_o,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/mpx_fsm.sv
module mpx_fsm
  import mpx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    wait_zero_i,
  input  logic    wait_last_i,
  input  logic    rdy_n_i,
  output mpx_st_e state_o,
  output logic    accept_o,
  output logic    dec_o,
  output logic    done_o
);
  mpx_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    accept_o = 1'b0;
    dec_o    = 1'b0;
    done_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        st_d     = ST_HDR;
      end
      ST_HDR:   st_d = wait_zero_i ? ST_DATA : ST_IWAIT;
      ST_IWAIT: begin
        dec_o = 1'b1;
        if (wait_last_i) st_d = ST_DATA;
      end
      ST_DATA: if (!rdy_n_i) begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/mpx_wr_master.sv
module mpx_wr_master
  import mpx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 26,
  parameter int SIZE_W = 3,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [WAIT_W-1:0] req_wait_i,
  output logic              done_o,
  input  logic              rdy_n_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              cs_n_o,
  output logic              bs_n_o,
  output logic              frame_n_o,
  output logic              we_n_o
);
  mpx_st_e           state;
  logic              accept, dec, wait_zero, wait_last;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] data_q, hdr;

  mpx_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .wait_zero_i (wait_zero),
    .wait_last_i (wait_last),
    .rdy_n_i     (rdy_n_i),
    .state_o     (state),
    .accept_o    (accept),
    .dec_o       (dec),
    .done_o      (done_o)
  );

  mpx_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (req_wait_i),
    .dec_i      (dec),
    .zero_o     (wait_zero),
    .last_o     (wait_last)
  );

  mpx_hdr_fmt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_hdr (
    .size_i (size_q),
    .addr_i (addr_q),
    .hdr_o  (hdr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      size_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      size_q <= req_size_i;
      data_q <= req_data_i;
    end
  end

  logic busy;
  assign busy        = (state != ST_IDLE);
  assign req_ready_o = !busy;
  assign cs_n_o      = !busy;
  assign we_n_o      = !busy;
  assign frame_n_o   = !busy;
  assign bs_n_o      = (state != ST_HDR);

  always_comb begin
    unique case (state)
      ST_HDR:            bus_d_o = hdr;
      ST_IWAIT, ST_DATA: bus_d_o = data_q;
      default:           bus_d_o = '0;
    endcase
  end
endmodule

// File: rtl/mpx_wr_master_chk.sv
module mpx_wr_master_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 26,
  parameter int SIZE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [DATA_W-1:0] bus_d_o,
  input logic              cs_n_o,
  input logic              bs_n_o,
  input logic              frame_n_o,
  input logic              we_n_o
);
  // R3
  bs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_n_o |=> bs_n_o);
  // R4
  bs_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_n_o |-> !frame_n_o && !cs_n_o);
  // R2
  hdr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_n_o |-> bus_d_o[DATA_W-SIZE_W-1:ADDR_W] == '0);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cs_n_o && we_n_o && frame_n_o);
  // R10
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_o |-> !req_ready_o);
endmodule

bind mpx_wr_master mpx_wr_master_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
) u_chk (.*);

// File: tb/mpx_wr_master_bench.sv
module mpx_wr_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [63:0] req_data = '0;
  logic [3:0]  req_wait = '0;
  logic        done;
  logic        rdy_n = 1'b0;
  logic [63:0] bus_d;
  logic        cs_n, bs_n, frame_n, we_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mpx_wr_master u_mpx_wr_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_data_i(req_data),
    .req_wait_i(req_wait), .done_o(done), .rdy_n_i(rdy_n), .bus_d_o(bus_d),
    .cs_n_o(cs_n), .bs_n_o(bs_n), .frame_n_o(frame_n), .we_n_o(we_n)
  );

  // reference model: 0 idle, 1 header, 2 internal wait, 3 data
  int          m_ph = 0;
  int          m_wait = 0;
  int          m_ext = 0;
  logic [25:0] m_addr;
  logic [2:0]  m_size;
  logic [63:0] m_data;
  int          ext_cfg = 0;
  logic        iw_rdy = 1'b0;
  int          frame_cycles = 0;
  int          done_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ph = 0;
    else case (m_ph)
      0: if (req_valid) begin
        m_addr = req_addr; m_size = req_size; m_data = req_data;
        m_wait = req_wait; m_ext = ext_cfg; m_ph = 1;
      end
      1: m_ph = (m_wait == 0) ? 3 : 2;
      2: begin m_wait--; if (m_wait == 0) m_ph = 3; end
      default: if (!rdy_n) m_ph = 0; else m_ext--;
    endcase
  end

  // ready driver from the model's own phase
  always @(negedge clk) begin
    if (m_ph == 3) rdy_n = (m_ext > 0);
    else if (m_ph == 2) rdy_n = iw_rdy;
    else rdy_n = 1'b0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    begin
      logic [63:0] e_d;
      logic        busy;
      busy = (m_ph != 0);
      e_d  = (m_ph == 1) ? {m_size, 35'd0, m_addr} : (busy ? m_data : 64'd0);
      if (m_ph == 1) chk("R2 header", bus_d, e_d);
      else if (m_ph == 2) chk("R6 wait data", bus_d, e_d);
      else chk("R1 bus", bus_d, e_d);
      chk("R3 bs_n", 64'(bs_n), 64'(m_ph != 1));
      chk("R4 frame_n", 64'(frame_n), 64'(!busy));
      chk("R5 cs_n", 64'(cs_n), 64'(!busy));
      chk("R5 we_n", 64'(we_n), 64'(!busy));
      chk("R10 req_ready", 64'(req_ready), 64'(!busy));
      chk("R9 done", 64'(done), 64'(m_ph == 3 && !rdy_n));
      if (!frame_n) frame_cycles++;
      if (done) done_cnt++;
    end
  end

  task automatic do_write(input logic [25:0] a, input logic [2:0] s, input logic [63:0] d,
                          input int w, input int e, input logic iwr, input logic hold_valid,
                          input string req);
    while (m_ph != 0) @(negedge clk);
    req_addr = a; req_size = s; req_data = d; req_wait = 4'(w);
    ext_cfg = e; iw_rdy = iwr; req_valid = 1'b1;
    frame_cycles = 0; done_cnt = 0;
    @(negedge clk);
    if (!hold_valid) req_valid = 1'b0;
    else begin req_addr = ~a; req_data = ~d; end
    while (m_ph != 0) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk); #3;
    chk({req, " frame length"}, 64'(frame_cycles), 64'(2 + w + e));
    chk("R9 done count", 64'(done_cnt), 64'd1);
  endtask

  initial begin
    #5;
    chk("R1 reset cs_n", 64'(cs_n), 64'd1);
    chk("R1 reset frame_n", 64'(frame_n), 64'd1);
    chk("R1 reset bus", bus_d, 64'd0);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    #40 rst_n = 1'b1;
    @(negedge clk);
    do_write(26'h0012345, 3'b000, 64'h0123_4567_89ab_cdef, 0, 0, 1'b0, 1'b0, "R11");
    do_write(26'h3ffffff, 3'b001, 64'hffff_0000_ffff_0000, 1, 0, 1'b0, 1'b0, "R6");
    do_write(26'h2aaaaaa, 3'b010, 64'hdead_beef_cafe_f00d, 1, 1, 1'b0, 1'b0, "R8");
    do_write(26'h1555555, 3'b011, 64'h5555_aaaa_5555_aaaa, 3, 0, 1'b1, 1'b0, "R7");
    do_write(26'h0000001, 3'b111, 64'h8000_0000_0000_0001, 2, 4, 1'b1, 1'b0, "R8");
    do_write(26'h3ffffff, 3'b100, 64'hffff_ffff_ffff_ffff, 0, 2, 1'b0, 1'b1, "R10");
    do_write(26'h0abcdef, 3'b101, 64'h0f0f_0f0f_0f0f_0f0f, 15, 0, 1'b1, 1'b0, "R6");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule